// File: doc/BRIEF.md
# Ethernet Link Pulse Burst Generator

This block produces the digital pulse train that a 10/100 copper PHY puts on the wire while no link is up. A free-running period timer (16 ms by default) marks the start of each period. With auto-negotiation enabled, every period opens with a burst of up to 33 pulse slots. The even slots always carry a clock pulse. Each odd slot carries one bit of a 16-bit advertisement word: a pulse means 1 and no pulse means 0.

With auto-negotiation disabled, the speed select bit picks one of two forced modes. Forced 10M emits one lone link pulse at the start of every period. Forced 100M emits nothing and raises an idle flag, so the downstream line coder can send its own idle symbols.

The control word and the advertisement word are sampled only on the first cycle of a period. The mode and the burst contents therefore never change partway through a period. All timing constants default to values computed from a clock-frequency parameter, and each can be overridden.

Top module: `link_pulse_gen`

## Requirements
- R1: While `rst_n` is low, `pulse_o` is 0, `mode_o` is 0 and `idle100_o` is 0. The first period begins on the first clock edge after reset is released, and a reset asserted mid-period restarts the timer.
- R2: Periods start every GAP_CYC cycles. The default is 16 ms worth of cycles of CLK_HZ.
- R3: In burst mode a period holds 33 slots, numbered 0 to 32, each SLOT_CYC cycles long. Every even slot carries a pulse, so a burst has 17 clock pulses plus one pulse per set advertisement bit.
- R4: Odd slot 2k+1 carries advertisement bit k, so bit 0 is sent first. A pulse is present when the bit is 1 and absent when it is 0.
- R5: A pulse is high for PULSE_CYC cycles, starting on the first cycle of its slot. The defaults are 100 ns of high time and a slot of 62.5 us, which places clock pulses 125 us apart.
- R6: `ctrl_i[12]`=1 selects burst mode and reports `mode_o`=0.
- R7: `ctrl_i[12]`=0 with `ctrl_i[13]`=0 selects forced 10M and reports `mode_o`=1. Exactly one pulse is sent, on the first cycle of each period.
- R8: `ctrl_i[12]`=0 with `ctrl_i[13]`=1 selects forced 100M and reports `mode_o`=2. `idle100_o` is 1 and `pulse_o` stays low.
- R9: `adv_i` is sampled on the first cycle of a period. A change made later in the period only affects the next burst.
- R10: `ctrl_i` is sampled on the first cycle of a period. `mode_o` changes only at a period start, and the output pattern follows the new mode from that period on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at CLK_HZ |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_i | input | 16 | Control word; bit 12 enables auto-negotiation, bit 13 selects 100M when it is off |
| adv_i | input | 16 | Advertisement word carried in bursts |
| pulse_o | output | 1 | Link pulse line |
| mode_o | output | 2 | Current mode: 0 burst, 1 forced 10M, 2 forced 100M |
| idle100_o | output | 1 | High while in forced 100M idle mode |

## Verification
Bursts are driven with all-zero, all-one, a single low bit and a mixed pattern. All-zero and all-one separate clock slots from data slots. The single low bit catches a bit-order or slot-index error. The mixed word catches swapped neighbouring bits. Both forced modes are then run on their own, and each is tested against a change of control or advertisement made partway through a period: the old pattern must run to the end of the period. A reset applied in the middle of a burst checks that the timer restarts from the first slot.

// File: rtl/link_pulse_gen.sv
module link_pulse_gen #(
  parameter int CLK_HZ    = 125_000_000,
  parameter int PULSE_CYC = CLK_HZ / 10_000_000,
  parameter int SLOT_CYC  = CLK_HZ / 16_000,
  parameter int GAP_CYC   = (CLK_HZ / 1000) * 16,
  parameter int AN_BIT    = 12,
  parameter int SPD_BIT   = 13
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] ctrl_i,
  input  logic [15:0] adv_i,
  output logic        pulse_o,
  output logic [1:0]  mode_o,
  output logic        idle100_o
);
  localparam int CW = $clog2(GAP_CYC);
  localparam int SW = $clog2(SLOT_CYC);
  localparam logic [CW-1:0] GAP_LAST  = CW'(GAP_CYC - 1);
  localparam logic [CW-1:0] NLP_LEN   = CW'(PULSE_CYC);
  localparam logic [SW-1:0] SLOT_LAST = SW'(SLOT_CYC - 1);
  localparam logic [SW-1:0] HEAD_LEN  = SW'(PULSE_CYC);
  localparam logic [5:0]    LAST_SLOT = 6'd32;

  logic [CW-1:0] cnt;
  logic [SW-1:0] sub;
  logic [5:0]    slot;
  logic [1:0]    mode_q, live_mode, eff_mode;
  logic [15:0]   word_q, eff_word;
  logic          pulse_q, hit;

  wire start = (cnt == '0);
  assign live_mode = ctrl_i[AN_BIT] ? 2'd0 : (ctrl_i[SPD_BIT] ? 2'd2 : 2'd1);
  assign eff_mode  = start ? live_mode : mode_q;
  assign eff_word  = start ? adv_i : word_q;

  wire burst_hit = (slot <= LAST_SLOT) && (sub < HEAD_LEN) &&
                   (!slot[0] || eff_word[slot[4:1]]);

  always_comb begin
    case (eff_mode)
      2'd0:    hit = burst_hit;
      2'd1:    hit = (cnt < NLP_LEN);
      default: hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      sub     <= '0;
      slot    <= '0;
      mode_q  <= 2'd0;
      word_q  <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= hit;
      if (start) begin
        mode_q <= live_mode;
        word_q <= adv_i;
      end
      if (cnt == GAP_LAST) begin
        cnt  <= '0;
        sub  <= '0;
        slot <= '0;
      end else begin
        cnt <= cnt + 1'b1;
        if (sub == SLOT_LAST) begin
          sub <= '0;
          if (slot <= LAST_SLOT) slot <= slot + 1'b1;
        end else begin
          sub <= sub + 1'b1;
        end
      end
    end
  end

  assign pulse_o   = pulse_q;
  assign mode_o    = mode_q;
  assign idle100_o = (mode_q == 2'd2);
endmodule

// File: rtl/link_pulse_gen_chk.sv
module link_pulse_gen_chk #(
  parameter int PULSE_CYC = 12,
  parameter int GAP_CYC   = 2_000_000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       pulse_o,
  input logic [1:0] mode_o,
  input logic       idle100_o
);
  localparam int CW = $clog2(GAP_CYC);
  localparam int HW = $clog2(PULSE_CYC + 2);
  logic [CW-1:0] pc;
  logic [HW-1:0] hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc <= '0;
      hi <= '0;
    end else begin
      pc <= (pc == CW'(GAP_CYC - 1)) ? '0 : pc + 1'b1;
      hi <= pulse_o ? ((hi == HW'(PULSE_CYC + 1)) ? hi : hi + 1'b1) : '0;
    end
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> (!pulse_o && mode_o == 2'd0 && !idle100_o));

  a_r5_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_o |-> (hi < HW'(PULSE_CYC)));

  a_r8_idle_silent: assert property (@(posedge clk) disable iff (!rst_n)
    idle100_o |-> (!pulse_o && mode_o == 2'd2));

  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd1 && pc > CW'(PULSE_CYC)) |-> !pulse_o);

  a_r10_mode_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mode_o) |-> (pc == CW'(1)));
endmodule

bind link_pulse_gen link_pulse_gen_chk #(.PULSE_CYC(PULSE_CYC), .GAP_CYC(GAP_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .pulse_o(pulse_o), .mode_o(mode_o), .idle100_o(idle100_o)
);

// File: tb/link_pulse_gen_tb.sv
`timescale 1ns/1ps
module link_pulse_gen_tb;
  localparam int PULSE = 2;
  localparam int SLOT  = 10;
  localparam int GAP   = 800;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ctrl = 16'h1000;
  logic [15:0] adv = 16'h0000;
  logic        pulse;
  logic [1:0]  mode;
  logic        idle;

  int vectors = 0;
  int errors = 0;
  int k = 0;
  int p = 0;
  int mm = 0;
  logic [15:0] mw = '0;
  bit done = 0;

  always #4 clk = ~clk;

  link_pulse_gen #(.CLK_HZ(125_000_000), .PULSE_CYC(PULSE), .SLOT_CYC(SLOT), .GAP_CYC(GAP)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_i(ctrl), .adv_i(adv),
    .pulse_o(pulse), .mode_o(mode), .idle100_o(idle)
  );

  function automatic int ctrl_mode(logic [15:0] c);
    if (c[12]) return 0;
    return c[13] ? 2 : 1;
  endfunction

  function automatic logic model(int md, logic [15:0] w, int pos);
    int s;
    int u;
    s = pos / SLOT;
    u = pos % SLOT;
    if (md == 0) return (s <= 32) && (u < PULSE) && ((s % 2 == 0) || w[s / 2]);
    if (md == 1) return pos < PULSE;
    return 1'b0;
  endfunction

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s k=%0d p=%0d actual=%0d expected=%0d", tag, k, p, act, exp);
    end
  endtask

  task automatic step(string tag);
    logic e;
    @(negedge clk);
    if (!rst_n) begin
      k = 0;
      mm = 0;
      check("R1 reset pulse", int'(pulse), 0);
      check("R1 reset mode", int'(mode), 0);
      check("R1 reset idle", int'(idle), 0);
    end else begin
      k++;
      p = (k - 1) % GAP;
      if (p == 0) begin
        mm = ctrl_mode(ctrl);
        mw = adv;
      end
      e = model(mm, mw, p);
      check(tag, int'(pulse), int'(e));
      check("R10 mode", int'(mode), mm);
      check("R8 idle", int'(idle), int'(mm == 2));
    end
  endtask

  task automatic sync(string tag);
    while (!(rst_n && p == GAP - 1 && k > 0)) step(tag);
  endtask

  task automatic measure(string tag, int exp_hi);
    int hi = 0;
    for (int i = 0; i < GAP; i++) begin
      step(tag);
      if (pulse) hi++;
    end
    check({tag, " count"}, hi, exp_hi);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    for (int i = 0; i < 4; i++) step("R1");
    rst_n = 1'b1;
    step("R1 first slot");
    check("R1 pulse at start", int'(pulse), 1);
  endtask

  task automatic t_burst(logic [15:0] w);
    ctrl = 16'h1000;
    adv = w;
    sync("R3/R4/R5");
    measure("R3/R4/R5 R6 burst", (17 + $countones(w)) * PULSE);
  endtask

  task automatic t_nlp();
    int first = -1;
    int second = -1;
    logic prev = 1'b0;
    ctrl = 16'h0000;
    sync("R7");
    for (int i = 0; i < 2 * GAP; i++) begin
      step("R7 single pulse");
      if (pulse && !prev) begin
        if (first < 0) first = k; else if (second < 0) second = k;
      end
      prev = pulse;
    end
    check("R2 period", second - first, GAP);
    measure("R7", PULSE);
  endtask

  task automatic t_idle();
    ctrl = 16'h2000;
    sync("R8");
    measure("R8 silent", 0);
    check("R8 idle flag", int'(idle), 1);
  endtask

  task automatic t_adv_mid();
    ctrl = 16'h1000;
    adv = 16'h00FF;
    sync("R9");
    for (int i = 0; i < 50; i++) step("R9 old word");
    adv = 16'hFF01;
    while (p != GAP - 1) step("R9 old word");
    measure("R9 new word", (17 + 9) * PULSE);
  endtask

  task automatic t_ctrl_mid();
    ctrl = 16'h1000;
    adv = 16'h0F0F;
    sync("R10");
    for (int i = 0; i < 100; i++) step("R10 burst kept");
    ctrl = 16'h2000;
    while (p != GAP - 1) step("R10 burst kept");
    check("R10 mode held", int'(mode), 0);
    measure("R10 switched", 0);
    ctrl = 16'h0000;
    sync("R10");
    measure("R10 to 10M", PULSE);
  endtask

  task automatic t_reset_mid();
    ctrl = 16'h1000;
    adv = 16'hFFFF;
    sync("R1");
    for (int i = 0; i < 30; i++) step("R1 pre");
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) step("R1 mid reset");
    rst_n = 1'b1;
    measure("R1 restart", (17 + 16) * PULSE);
  endtask

  initial begin
    t_reset();
    t_burst(16'h0000);
    t_burst(16'hFFFF);
    t_burst(16'hFFFE);
    t_burst(16'hA5C3);
    t_nlp();
    t_idle();
    t_adv_mid();
    t_ctrl_mid();
    t_reset_mid();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule